// File: doc/BRIEF.md
# Retriggerable Resettable Digital One-Shot

A synchronous monostable timer that produces a pulse of programmable length, counted in clock cycles. It has two trigger inputs. A rising edge on `trig_a_i` fires the pulse when `trig_b_i` is high. A falling edge on `trig_b_i` fires it when `trig_a_i` is low. Tying the unused input to its enabling level gives either a rising-edge or a falling-edge trigger. Both inputs are asynchronous. They pass through a two-flop synchronizer, and edges are found by comparing each synchronized sample with the one before it. The gating level comes from the same synchronized sample as the edge.

The pulse appears on `q_o` and its complement on `qn_o`. The `retrig_i` input chooses the response to a trigger that arrives while the pulse is active. When `retrig_i` is 1, the trigger restarts the full width, measured from that trigger. When `retrig_i` is 0, the trigger is ignored. An active-low reset clears the outputs at once. Its release is synchronized, and a short priming interval follows during which no edge is accepted. A second channel is built by instantiating the block again.

The control is a four-state machine:
- **RESET**: reset is held.
- **PRIME**: the synchronizer pipeline refills.
- **IDLE**: the block waits for a trigger.
- **PULSE**: the pulse is being timed.

The transitions are:
- **release**: RESET to PRIME.
- **primed**: PRIME to IDLE.
- **fire**: IDLE to PULSE, on a valid trigger with a non-zero width.
- **reload**: PULSE to PULSE, on a retrigger.
- **count**: PULSE to PULSE, decrementing the counter.
- **expire**: PULSE to IDLE, at the last cycle.
- **cancel**: PULSE to IDLE, on a retrigger while the width is zero.

Top module: `osh_oneshot`

## Requirements
- R1: A 0-to-1 change on trig_a_i while trig_b_i is high starts a pulse; q_o rises on the third clock edge after the input change.
- R2: A 1-to-0 change on trig_b_i while trig_a_i is low starts a pulse with the same latency as R1.
- R3: No pulse starts on any of these changes:
  - trig_a_i rising while trig_b_i is low;
  - trig_b_i falling while trig_a_i is high;
  - trig_a_i falling;
  - trig_b_i rising.
- R4: q_o stays high for exactly width_i clock cycles; a trigger from idle with width_i = 0 gives no pulse.
- R5: qn_o is always the inverse of q_o.
- R6: While rst_n is low, q_o is low and qn_o is high, with no clock needed, and no trigger is accepted.
- R7: Inputs already at a triggering level when rst_n is released start no pulse.
- R8: With retrig_i = 1, a valid trigger during a pulse restarts the full width_i count, measured from that trigger.
- R9: With retrig_i = 0, triggers during a pulse are ignored, and the pulse ends at its original time.
- R10: Triggers arriving at the fastest rate one input allows (every second cycle) are each honoured; there is no dead time after a trigger.
- R11: With retrig_i = 1, a retrigger while width_i = 0 ends the pulse at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asserts immediately, release synchronized |
| trig_a_i | input | 1 | Rising-edge trigger, enabled by trig_b_i high |
| trig_b_i | input | 1 | Falling-edge trigger, enabled by trig_a_i low |
| retrig_i | input | 1 | 1: a trigger during a pulse restarts it; 0: it is ignored |
| width_i | input | WIDTH_BITS | Pulse length in clock cycles |
| q_o | output | 1 | Pulse output, active high |
| qn_o | output | 1 | Complement of q_o |

## Verification
The assertions check these properties on every cycle:
- The two outputs stay complementary.
- q_o stays low while the synchronized reset is low, and in the cycle after its release.
- An idle cycle with zero width never raises q_o.
- A retrigger reloads the counter with the current width.
- In non-retriggerable mode the counter only counts down by one.
- The counter never decrements through zero.

Only the bench scenarios can show the end-to-end behaviour:
- The three-edge latency from a pin change to q_o.
- The exact pulse lengths.
- The rejection of unqualified edges.
- The asynchronous clear in the middle of a pulse.
- The quiet start with the inputs held at triggering levels.
- Triggers arriving every second cycle, each one honoured.

// File: rtl/osh_pkg.sv
package osh_pkg;
    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_PRIME = 2'd1,
        ST_IDLE  = 2'd2,
        ST_PULSE = 2'd3
    } osh_state_e;
endpackage

// File: rtl/osh_sync.sv
module osh_sync #(
    parameter int   W       = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= {W{RST_VAL}};
                else        pipe[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= {W{RST_VAL}};
                else        pipe[g] <= pipe[g-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/osh_trig.sv
module osh_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic a_s,
    input  logic b_s,
    output logic fire
);
    logic a_prev, b_prev;
    logic a_rise, b_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_prev <= 1'b0;
            b_prev <= 1'b0;
        end else begin
            a_prev <= a_s;
            b_prev <= b_s;
        end
    end

    always_comb begin
        a_rise = a_s & ~a_prev;
        b_fall = ~b_s & b_prev;
        fire   = (a_rise & b_s) | (b_fall & ~a_s);
    end
endmodule

// File: rtl/osh_timer.sv
module osh_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= load_val;
        else if (dec)  cnt <= cnt - 1'b1;
    end

    assign last = (cnt == {{(CW-1){1'b0}}, 1'b1});

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt != '0)); // R4
    AST_LOAD_XOR_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && dec)); // R8
endmodule

// File: rtl/osh_oneshot.sv
module osh_oneshot
    import osh_pkg::*;
#(
    parameter int WIDTH_BITS   = 16,
    parameter int SYNC_STAGES  = 2,
    parameter int PRIME_CYCLES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  trig_a_i,
    input  logic                  trig_b_i,
    input  logic                  retrig_i,
    input  logic [WIDTH_BITS-1:0] width_i,
    output logic                  q_o,
    output logic                  qn_o
);
    localparam int PW = $clog2(PRIME_CYCLES + 1);
    localparam logic [PW-1:0] PRIME_LAST = PW'(PRIME_CYCLES - 1);

    osh_state_e            state, nxt;
    logic                  rst_s_n;
    logic [1:0]            ab_s;
    logic                  fire;
    logic [PW-1:0]         prime_cnt;
    logic                  tmr_load, tmr_dec, tmr_last;
    logic [WIDTH_BITS-1:0] tmr_cnt;
    logic                  q_r, qn_r;

    // release of reset is synchronized; assertion is immediate
    osh_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (1'b1),
        .q     (rst_s_n)
    );

    osh_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_in_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({trig_a_i, trig_b_i}),
        .q     (ab_s)
    );

    osh_trig u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .a_s   (ab_s[1]),
        .b_s   (ab_s[0]),
        .fire  (fire)
    );

    osh_timer #(.CW(WIDTH_BITS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (width_i),
        .dec      (tmr_dec),
        .cnt      (tmr_cnt),
        .last     (tmr_last)
    );

    // next state and timer control
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_dec  = 1'b0;
        unique case (state)
            ST_RESET: begin
                if (rst_s_n) nxt = ST_PRIME;                    // release
            end
            ST_PRIME: begin
                if (prime_cnt == PRIME_LAST) nxt = ST_IDLE;     // primed
            end
            ST_IDLE: begin
                if (fire && (width_i != '0)) begin              // fire
                    nxt      = ST_PULSE;
                    tmr_load = 1'b1;
                end
            end
            ST_PULSE: begin
                if (fire && retrig_i) begin
                    if (width_i == '0) nxt = ST_IDLE;           // cancel
                    else               tmr_load = 1'b1;         // reload
                end else if (tmr_last) begin
                    nxt = ST_IDLE;                              // expire
                end else begin
                    tmr_dec = 1'b1;                             // count
                end
            end
            default: nxt = ST_RESET;
        endcase
        if (!rst_s_n) begin
            nxt      = ST_RESET;
            tmr_load = 1'b0;
            tmr_dec  = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_RESET;
            prime_cnt <= '0;
        end else begin
            state     <= nxt;
            prime_cnt <= (state == ST_PRIME) ? prime_cnt + 1'b1 : '0;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r  <= 1'b0;
            qn_r <= 1'b1;
        end else begin
            q_r  <= (nxt == ST_PULSE);
            qn_r <= (nxt != ST_PULSE);
        end
    end

    assign q_o  = q_r;
    assign qn_o = qn_r;

    AST_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        qn_o == ~q_o); // R5
    AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_s_n |-> !q_o); // R6
    AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_s_n) |=> !q_o); // R7
    AST_ZERO_NOPULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && width_i == '0) |=> !q_o); // R4
    AST_RETRIG_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULSE && retrig_i && fire && width_i != '0 && rst_s_n)
        |=> (q_o && tmr_cnt == $past(width_i))); // R8
    AST_NORETRIG_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULSE && !retrig_i && !tmr_last && rst_s_n)
        |=> (tmr_cnt == $past(tmr_cnt) - 1'b1)); // R9
endmodule

// File: tb/osh_oneshot_tb.sv
module osh_oneshot_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        a = 1'b0;
    logic        b = 1'b1;
    logic        retrig = 1'b1;
    logic [15:0] width = 16'd5;
    logic        q, qn;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    osh_oneshot #(.WIDTH_BITS(16)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_a_i (a),
        .trig_b_i (b),
        .retrig_i (retrig),
        .width_i  (width),
        .q_o      (q),
        .qn_o     (qn)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic exp_q);
        checks++;
        if (q !== exp_q) begin
            errors++;
            $display("FAIL %s: q=%b expected %b at %0t", tag, q, exp_q, $time);
        end
        checks++;
        if (qn !== ~exp_q) begin
            errors++;
            $display("FAIL R5 (%s): qn=%b expected %b at %0t", tag, qn, ~exp_q, $time);
        end
    endtask

    task automatic settle();
        for (int i = 0; i < 16; i++) tick();
    endtask

    task automatic quiet(string tag, int n);
        for (int i = 0; i < n; i++) begin tick(); chk(tag, 1'b0); end
    endtask

    // R6: reset holds outputs and ignores triggers; R7: quiet release
    task automatic t_reset_hold();
        tick(); chk("R6", 1'b0);
        a = 1'b1; quiet("R6", 6);
        a = 1'b0; quiet("R6", 2);
        rst_n = 1'b1; quiet("R7", 10);
    endtask

    // R1 + R4: A rising with B high, width 5
    task automatic t_a_rise();
        a = 1'b0; b = 1'b1; width = 16'd5; settle();
        a = 1'b1;
        for (int i = 1; i <= 10; i++) begin
            tick(); chk("R1/R4", (i >= 3 && i <= 7));
        end
        a = 1'b0; quiet("R3 a-fall", 8);
    endtask

    // R2 + R4: B falling with A low, width 3
    task automatic t_b_fall();
        a = 1'b0; b = 1'b1; width = 16'd3; settle();
        b = 1'b0;
        for (int i = 1; i <= 8; i++) begin
            tick(); chk("R2/R4", (i >= 3 && i <= 5));
        end
        b = 1'b1; quiet("R3 b-rise", 8);
    endtask

    // R3: edges without the enabling level
    task automatic t_unqualified();
        width = 16'd4;
        a = 1'b0; b = 1'b0; settle();
        a = 1'b1; quiet("R3 a-rise b-low", 8);
        b = 1'b1; quiet("R3 b-rise", 6);
        b = 1'b0; quiet("R3 b-fall a-high", 8);
        b = 1'b1; tick(); a = 1'b0; quiet("R3 a-fall", 8);
    endtask

    // R4: zero width from idle gives nothing
    task automatic t_width_zero();
        a = 1'b0; b = 1'b1; width = 16'd0; settle();
        a = 1'b1; quiet("R4 zero", 10);
        a = 1'b0; width = 16'd5; settle();
    endtask

    // R8: retrigger restarts full width
    task automatic t_retrig();
        a = 1'b0; b = 1'b1; retrig = 1'b1; width = 16'd6; settle();
        a = 1'b1;
        for (int i = 1; i <= 16; i++) begin
            tick(); chk("R8", (i >= 3 && i <= 13));
            if (i == 4) a = 1'b0;
            if (i == 5) a = 1'b1;
        end
        a = 1'b0; settle();
    endtask

    // R9: non-retriggerable ignores triggers during pulse
    task automatic t_noretrig();
        a = 1'b0; b = 1'b1; retrig = 1'b0; width = 16'd6; settle();
        a = 1'b1;
        for (int i = 1; i <= 16; i++) begin
            tick(); chk("R9", (i >= 3 && i <= 8));
            if (i == 4) a = 1'b0;
            if (i == 5) a = 1'b1;
        end
        a = 1'b0; retrig = 1'b1; settle();
    endtask

    // R10: triggers every second cycle each restart the count
    task automatic t_dense();
        a = 1'b0; b = 1'b1; retrig = 1'b1; width = 16'd4; settle();
        a = 1'b1;
        for (int i = 1; i <= 13; i++) begin
            tick(); chk("R10", (i >= 3 && i <= 10));
            if (i == 1 || i == 3) a = 1'b0;
            if (i == 2 || i == 4) a = 1'b1;
        end
        a = 1'b0; settle();
    endtask

    // R11: retrigger with zero width cancels the pulse
    task automatic t_cancel();
        a = 1'b0; b = 1'b1; retrig = 1'b1; width = 16'd8; settle();
        a = 1'b1;
        for (int i = 1; i <= 12; i++) begin
            tick(); chk("R11", (i >= 3 && i <= 7));
            if (i == 4) a = 1'b0;
            if (i == 5) begin a = 1'b1; width = 16'd0; end
        end
        a = 1'b0; width = 16'd5; settle();
    endtask

    // R6 async clear mid-pulse, R7 release with valid levels, then R1 alive
    task automatic t_async_reset();
        a = 1'b0; b = 1'b1; width = 16'd8; settle();
        a = 1'b1;
        for (int i = 1; i <= 4; i++) tick();
        chk("R1 pre-reset", 1'b1);
        #1 rst_n = 1'b0;
        #1 chk("R6 async", 1'b0);
        quiet("R6", 3);
        a = 1'b1; b = 1'b1;
        tick(); rst_n = 1'b1;
        quiet("R7", 12);
        a = 1'b0; width = 16'd3; settle();
        a = 1'b1;
        for (int i = 1; i <= 7; i++) begin
            tick(); chk("R1 after reset", (i >= 3 && i <= 5));
        end
        a = 1'b0;
    endtask

    initial begin
        #1 rst_n = 1'b0;
        t_reset_hold();
        t_a_rise();
        t_b_fall();
        t_unqualified();
        t_width_zero();
        t_retrig();
        t_noretrig();
        t_dense();
        t_cancel();
        t_async_reset();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule